// File: doc/BRIEF.md
# Temperature Channel Fault Substitution

This block sits between the conversion engine of a multi-channel remote-diode temperature sensor and the register file that software reads. Every channel delivers a measured high byte and a measured low byte, an open-circuit detect flag, a short-circuit detect flag and a one-cycle conversion-done strobe. On that strobe the block stores the reading the register file will show. A channel with a live diode fault shows a fixed sentinel reading instead of the measured value. The block also records the fault in a sticky per-channel status bit and raises a summary fault flag.

Two of the channels, by default the third and fourth (indices 2 and 3), can be run as an anti-parallel diode pair. With the pair mode bit set, an open fault still belongs only to the channel that reports it. A short fault seen on either member of the pair counts as a fault on both members, because the two anti-parallel diodes share one wire pair. A read strobe from the status register path clears each sticky bit whose fault has gone away by that time and keeps each bit whose fault is still present.

Top module: `temp_fault_subst`

## Requirements
- R1: While reset is applied and right after it, every reported high and low byte is 0x00, every status bit is 0 and the summary flag is 0.
- R2: When a channel's conversion-done strobe is high and the channel has no effective fault, its reported high and low bytes take the measured bytes on that clock edge.
- R3: When a channel's conversion-done strobe is high and the channel has an effective fault (open or short), its reported high byte becomes 0x80 and its reported low byte becomes 0x00 on that clock edge.
- R4: A channel's reported bytes do not change in any cycle where its conversion-done strobe is low, whatever its measured bytes and detect flags do.
- R5: A strobe on a faulted channel sets that channel's status bit (bit i for channel i). The summary flag is 1 exactly when at least one status bit is 1.
- R6: With pair mode on, a short flag on either pair channel (index 2 or 3) is an effective fault for both of them, while an open flag is an effective fault only for the channel that raised it.
- R7: With pair mode off, the short flag of channel 3 is an effective fault only for channel 3, and the short flag of channel 2 only for channel 2.
- R8: On a status read strobe, each status bit whose channel has no effective fault at that time clears, and each bit whose channel still has an effective fault stays set.
- R9: Detect flags that are not accompanied by that channel's conversion-done strobe never set the channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| apd_mode | input | 1 | Pair mode: channels 2 and 3 share short faults |
| conv_done | input | NCH | Per-channel conversion-done strobe, bit i for channel i |
| meas_hi | input | NCH*8 | Measured high bytes, channel i in bits [8i+7:8i] |
| meas_lo | input | NCH*8 | Measured low bytes, channel i in bits [8i+7:8i] |
| open_det | input | NCH | Per-channel open-circuit detect flag |
| short_det | input | NCH | Per-channel short-circuit detect flag |
| fstat_rd | input | 1 | One-cycle strobe: the fault status register is being read |
| rpt_hi | output | NCH*8 | Reported high bytes |
| rpt_lo | output | NCH*8 | Reported low bytes |
| fault_bits | output | NCH | Sticky per-channel fault status |
| fault_any | output | 1 | Summary fault flag |

## Verification
The bench strobes one channel at a time and checks that its neighbours' readings stay the same. A design that decoded the strobe or the fault across channels would corrupt a healthy reading or miss a sentinel. It drives detect flags and new measured bytes with no strobe to expose a design that substitutes or sets status bits continuously rather than at conversion boundaries. In pair mode it applies a short on one member while only the other member strobes, and an open on one member only: a design without the shared short would report a real value, and one that also shared opens would wrongly fault the partner. Status reads are issued with the fault still present and again after it has gone, which catches a clear that ignores the live condition.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] tbyte_t;

  typedef struct packed {
    tbyte_t hi;
    tbyte_t lo;
  } reading_t;

  localparam tbyte_t FAULT_HI = 8'h80;
  localparam tbyte_t FAULT_LO = 8'h00;
endpackage

// File: rtl/tfs_rst_sync.sv
module tfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sync_q;
  logic [SW-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SW-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[SW-1];
endmodule

// File: rtl/tfs_fault_resolve.sv
module tfs_fault_resolve #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned PAIR_A = 2,
  parameter int unsigned PAIR_B = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           apd_mode,
  input  logic [NCH-1:0] open_det,
  input  logic [NCH-1:0] short_det,
  output logic [NCH-1:0] fault_eff
);
  // A short on either diode of the pair shorts the shared wire pair.
  logic pair_short;
  assign pair_short = short_det[PAIR_A] | short_det[PAIR_B];

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      if (g == PAIR_A || g == PAIR_B) begin : g_pair
        assign fault_eff[g] = open_det[g] | (apd_mode ? pair_short : short_det[g]);
      end else begin : g_single
        assign fault_eff[g] = open_det[g] | short_det[g];
      end
    end
  endgenerate

  // R6: shared short marks both pair channels
  assert_apd_share_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (apd_mode && (short_det[PAIR_A] || short_det[PAIR_B]))
      |-> (fault_eff[PAIR_A] && fault_eff[PAIR_B]));

  // R6: open on one pair member stays local
  assert_apd_open_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (apd_mode && open_det[PAIR_A] && !open_det[PAIR_B]
      && !short_det[PAIR_A] && !short_det[PAIR_B])
      |-> !fault_eff[PAIR_B]);

  // R7: with pair mode off, channel B's short does not reach channel A
  assert_apd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!apd_mode && short_det[PAIR_B] && !open_det[PAIR_A] && !short_det[PAIR_A])
      |-> !fault_eff[PAIR_A]);
endmodule

// File: rtl/tfs_chan_report.sv
module tfs_chan_report
  import tfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   done,
  input  logic   fault,
  input  tbyte_t meas_hi,
  input  tbyte_t meas_lo,
  output tbyte_t rpt_hi,
  output tbyte_t rpt_lo
);
  reading_t rd_q;
  reading_t rd_d;

  always_comb begin
    if (fault) begin
      rd_d.hi = FAULT_HI;
      rd_d.lo = FAULT_LO;
    end else begin
      rd_d.hi = meas_hi;
      rd_d.lo = meas_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (done) begin
      rd_q <= rd_d;
    end
  end

  assign rpt_hi = rd_q.hi;
  assign rpt_lo = rd_q.lo;

  // R4: reading frozen between strobes
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(rpt_hi) && $stable(rpt_lo)));

  // R3: faulted strobe leaves the sentinel
  assert_sentinel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |=> (rpt_hi == 8'h80 && rpt_lo == 8'h00));

  // R2: clean strobe passes the measured bytes
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |=> (rpt_hi == $past(meas_hi) && rpt_lo == $past(meas_lo)));
endmodule

// File: rtl/tfs_fault_status.sv
module tfs_fault_status #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_req,
  input  logic [NCH-1:0] live,
  input  logic           stat_rd,
  output logic [NCH-1:0] fault_bits,
  output logic           fault_any
);
  logic [NCH-1:0] bits_q;
  logic [NCH-1:0] bits_d;
  logic [NCH-1:0] clr_mask;
  logic           upd_en;

  always_comb begin
    clr_mask = stat_rd ? ~live : '0;
    bits_d   = (bits_q & ~clr_mask) | set_req;
    upd_en   = stat_rd | (|set_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (upd_en) begin
      bits_q <= bits_d;
    end
  end

  assign fault_bits = bits_q;
  assign fault_any  = |bits_q;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      // R5: faulted strobe sets the bit
      assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_req[g] |=> fault_bits[g]);

      // R8: read with fault gone clears the bit
      assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !live[g] && !set_req[g]) |=> !fault_bits[g]);

      // R8: read with fault present keeps the bit
      assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && live[g] && fault_bits[g]) |=> fault_bits[g]);

      // R9: a bit only rises after a set request
      assert_norise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_bits[g]) |-> $past(set_req[g]));
    end
  endgenerate

  // R5: summary rises only from a set request
  assert_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_any) |-> $past(|set_req));
endmodule

// File: rtl/temp_fault_subst.sv
module temp_fault_subst
  import tfs_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned PAIR_A = 2,
  parameter int unsigned PAIR_B = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apd_mode,
  input  logic [NCH-1:0]        conv_done,
  input  logic [NCH*BYTE_W-1:0] meas_hi,
  input  logic [NCH*BYTE_W-1:0] meas_lo,
  input  logic [NCH-1:0]        open_det,
  input  logic [NCH-1:0]        short_det,
  input  logic                  fstat_rd,
  output logic [NCH*BYTE_W-1:0] rpt_hi,
  output logic [NCH*BYTE_W-1:0] rpt_lo,
  output logic [NCH-1:0]        fault_bits,
  output logic                  fault_any
);
  localparam int unsigned BW = BYTE_W;

  logic           rst_n_s;
  logic [NCH-1:0] fault_eff;
  logic [NCH-1:0] set_req;

  tfs_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  tfs_fault_resolve #(.NCH(NCH), .PAIR_A(PAIR_A), .PAIR_B(PAIR_B)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .apd_mode  (apd_mode),
    .open_det  (open_det),
    .short_det (short_det),
    .fault_eff (fault_eff)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      tfs_chan_report u_rep (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .done    (conv_done[g]),
        .fault   (fault_eff[g]),
        .meas_hi (meas_hi[g*BW +: BW]),
        .meas_lo (meas_lo[g*BW +: BW]),
        .rpt_hi  (rpt_hi[g*BW +: BW]),
        .rpt_lo  (rpt_lo[g*BW +: BW])
      );
    end
  endgenerate

  assign set_req = conv_done & fault_eff;

  tfs_fault_status #(.NCH(NCH)) u_status (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .set_req    (set_req),
    .live       (fault_eff),
    .stat_rd    (fstat_rd),
    .fault_bits (fault_bits),
    .fault_any  (fault_any)
  );
endmodule

// File: tb/tb_temp_fault_subst.sv
`timescale 1ns/1ps
module tb_temp_fault_subst;
  localparam int NCH = 4;

  logic           clk;
  logic           rst_n;
  logic           apd_mode;
  logic [NCH-1:0] conv_done;
  logic [31:0]    meas_hi;
  logic [31:0]    meas_lo;
  logic [NCH-1:0] open_det;
  logic [NCH-1:0] short_det;
  logic           fstat_rd;
  logic [31:0]    rpt_hi;
  logic [31:0]    rpt_lo;
  logic [NCH-1:0] fault_bits;
  logic           fault_any;

  int n_checks = 0;
  int n_fail   = 0;

  temp_fault_subst dut (
    .clk(clk), .rst_n(rst_n), .apd_mode(apd_mode), .conv_done(conv_done),
    .meas_hi(meas_hi), .meas_lo(meas_lo), .open_det(open_det),
    .short_det(short_det), .fstat_rd(fstat_rd), .rpt_hi(rpt_hi),
    .rpt_lo(rpt_lo), .fault_bits(fault_bits), .fault_any(fault_any)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_meas(input int c, input logic [7:0] hi, input logic [7:0] lo);
    meas_hi[c*8 +: 8] = hi;
    meas_lo[c*8 +: 8] = lo;
  endtask

  task automatic chk_ch(input string req, input int c, input int hi, input int lo);
    chk(req, $sformatf("ch%0d hi", c), int'(rpt_hi[c*8 +: 8]), hi);
    chk(req, $sformatf("ch%0d lo", c), int'(rpt_lo[c*8 +: 8]), lo);
  endtask

  // Strobe at a falling edge; result registered at next rising edge, sampled at following falling edge.
  task automatic pulse_done(input logic [NCH-1:0] m);
    @(negedge clk); conv_done = m;
    @(negedge clk); conv_done = '0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); fstat_rd = 1'b1;
    @(negedge clk); fstat_rd = 1'b0;
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) chk_ch("R1", c, 0, 0);
    chk("R1", "fault_bits", int'(fault_bits), 0);
    chk("R1", "fault_any", int'(fault_any), 0);
  endtask

  task automatic t_pass();
    set_meas(0, 8'h19, 8'h20); set_meas(1, 8'h2a, 8'hE0);
    set_meas(2, 8'h7f, 8'hff); set_meas(3, 8'h00, 8'h60);
    pulse_done(4'b1111);
    chk_ch("R2", 0, 'h19, 'h20); chk_ch("R2", 1, 'h2a, 'hE0);
    chk_ch("R2", 2, 'h7f, 'hff); chk_ch("R2", 3, 'h00, 'h60);
    set_meas(1, 8'h81, 8'h40);
    pulse_done(4'b0010);
    chk_ch("R2", 1, 'h81, 'h40);
    chk_ch("R2", 0, 'h19, 'h20);
    chk("R2", "fault_bits", int'(fault_bits), 0);
  endtask

  task automatic t_hold();
    set_meas(0, 8'h55, 8'haa); set_meas(2, 8'h11, 8'h22);
    open_det = 4'b0101;
    repeat (3) @(negedge clk);
    chk_ch("R4", 0, 'h19, 'h20);
    chk_ch("R4", 2, 'h7f, 'hff);
    chk("R9", "fault_bits no strobe", int'(fault_bits), 0);
    chk("R9", "fault_any no strobe", int'(fault_any), 0);
    open_det = '0;
  endtask

  task automatic t_open_short();
    set_meas(1, 8'h30, 8'h80);
    open_det = 4'b0010;
    pulse_done(4'b0010);
    chk_ch("R3", 1, 'h80, 'h00);
    chk_ch("R4", 0, 'h19, 'h20);
    chk("R5", "fault_bits open", int'(fault_bits), 'b0010);
    chk("R5", "fault_any", int'(fault_any), 1);
    open_det = '0;
    short_det = 4'b0001;
    pulse_done(4'b0001);
    chk_ch("R3", 0, 'h80, 'h00);
    chk("R5", "fault_bits short", int'(fault_bits), 'b0011);
    short_det = '0;
  endtask

  task automatic t_clear();
    open_det = 4'b0010;
    pulse_rd();
    chk("R8", "read keeps live bit", int'(fault_bits), 'b0010);
    chk("R8", "reading untouched by read", int'(rpt_hi[8 +: 8]), 'h80);
    open_det = '0;
    pulse_rd();
    chk("R8", "read clears gone bits", int'(fault_bits), 0);
    chk("R5", "fault_any after clear", int'(fault_any), 0);
  endtask

  task automatic t_apd_on();
    apd_mode = 1'b1;
    set_meas(2, 8'h41, 8'h10); set_meas(3, 8'h42, 8'h20);
    short_det = 4'b1000;
    pulse_done(4'b0100);
    chk_ch("R6", 2, 'h80, 'h00);
    chk("R6", "fault_bits shared short", int'(fault_bits), 'b0100);
    short_det = 4'b0100;
    pulse_done(4'b1000);
    chk_ch("R6", 3, 'h80, 'h00);
    chk("R6", "fault_bits both", int'(fault_bits), 'b1100);
    short_det = '0;
    open_det = 4'b0100;
    pulse_rd();
    chk("R8", "pair read", int'(fault_bits), 'b0100);
    pulse_done(4'b1100);
    chk_ch("R6", 2, 'h80, 'h00);
    chk_ch("R6", 3, 'h42, 'h20);
    chk("R6", "open stays local", int'(fault_bits), 'b0100);
    open_det = '0;
    pulse_rd();
  endtask

  task automatic t_apd_off();
    apd_mode = 1'b0;
    set_meas(2, 8'h33, 8'h40); set_meas(3, 8'h34, 8'h60);
    short_det = 4'b1000;
    pulse_done(4'b1100);
    chk_ch("R7", 2, 'h33, 'h40);
    chk_ch("R7", 3, 'h80, 'h00);
    chk("R7", "fault_bits", int'(fault_bits), 'b1000);
    short_det = 4'b0100;
    pulse_done(4'b1100);
    chk_ch("R7", 2, 'h80, 'h00);
    chk_ch("R7", 3, 'h34, 'h60);
    short_det = '0;
  endtask

  initial begin
    rst_n = 1'b0; apd_mode = 1'b0; conv_done = '0; meas_hi = '0; meas_lo = '0;
    open_det = '0; short_det = '0; fstat_rd = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pass();
    t_hold();
    t_open_short();
    t_clear();
    t_apd_on();
    t_apd_off();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule